// File: doc/BRIEF.md
# Fractional-N Frequency Sweep Sequencer

This block drives the set-point of a fractional-N divider so that the synthesised frequency moves in linear ramps. The set-point is a 68-bit value: a 20-bit integer part above a 48-bit fraction. While a ramp runs, the block adds or subtracts a 48-bit step, aligned to the fraction LSB, once per reference period. When the programmed number of steps is done, it holds for a dwell time. After that it either reverses direction (two-way) or jumps back to the starting set-point (one-way).

A ramp is launched by a trigger. The trigger is either a register strobe or a rising edge on an external pin. A launch can be delayed by a programmable number of reference periods. With auto-repeat on, each leg follows the previous one without a new trigger. Step sizes, step counts and dwell times can differ between the rising and falling directions. Reference periods reach the block as a one-cycle tick in the system clock domain.

Top module: `sweep_seq`

## Requirements
- R1: After reset, `setpoint_o` is 0, `busy_o` is 0 and `dir_down_o` is 0.
- R2: During a ramp, the set-point changes by exactly one step on each `ref_tick_i` and never between ticks. It is added in 68-bit two's complement with the step placed on bits 47:0, so the fraction carries into or borrows from the integer part. After N steps the value is start ± step·N.
- R3: A rising leg uses `cnt_up_i` steps and `dwell_up_i` dwell periods. A falling leg uses `cnt_dn_i` and `dwell_dn_i`. Without a delay, `busy_o` covers exactly N + W reference ticks.
- R4: With `asym_i`=0, `step_up_i` is used in both directions. With `asym_i`=1, falling legs use `step_dn_i`.
- R5: The first trigger after reset, and every trigger in one-way mode, loads `start_val_i` and takes its direction from `start_down_i` (1 = decreasing).
- R6: In two-way mode (`one_way_i`=0), the end of a leg inverts `dir_down_o` and keeps the set-point. The next leg continues from there.
- R7: In one-way mode (`one_way_i`=1), the end of a leg returns the set-point to `start_val_i` and the direction to `start_down_i`.
- R8: With `auto_rpt_i`=1, the next leg starts at the end of the current one without a trigger. With `auto_rpt_i`=0, the block goes idle, which drops `busy_o`.
- R9: With `trig_sel_i`=0, only `trig_reg_i` triggers and the pin is ignored. With `trig_sel_i`=1, only a rising edge of `trig_pin_i`, after a two-flop synchroniser, triggers and the strobe is ignored.
- R10: With `dly_en_i`=1 and `dly_val_i`=D ≥ 1, the first step falls on the D-th reference tick after the trigger, so `busy_o` covers D−1+N+W ticks. D of 0 or 1 behaves like no delay.
- R11: A trigger that arrives while `busy_o` is 1 has no effect.
- R12: A leg with a step count of 0 makes no step. It only dwells and then ends as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One-cycle pulse per reference period |
| one_way_i | input | 1 | 1: jump back to start after each leg; 0: alternate direction |
| auto_rpt_i | input | 1 | Start the next leg without a trigger |
| start_down_i | input | 1 | Initial direction, 1 = decreasing |
| asym_i | input | 1 | Use separate step size for falling legs |
| trig_sel_i | input | 1 | Trigger source: 0 strobe, 1 pin edge |
| trig_reg_i | input | 1 | Register trigger strobe |
| trig_pin_i | input | 1 | Asynchronous external trigger pin |
| dly_en_i | input | 1 | Enable launch delay |
| dly_val_i | input | 48 | Launch delay in reference periods |
| start_val_i | input | 68 | Starting set-point (integer 67:48, fraction 47:0) |
| step_up_i | input | 48 | Rising step (both directions when symmetric) |
| step_dn_i | input | 48 | Falling step in asymmetric mode |
| cnt_up_i | input | 48 | Steps per rising leg |
| cnt_dn_i | input | 48 | Steps per falling leg |
| dwell_up_i | input | 48 | Dwell periods after a rising leg |
| dwell_dn_i | input | 48 | Dwell periods after a falling leg |
| setpoint_o | output | 68 | Current divider set-point |
| busy_o | output | 1 | A sweep leg or delay is in progress |
| dir_down_o | output | 1 | Direction of the current or next leg, 1 = decreasing |

## Verification
The hardest state to reach from the ports is an auto-repeating two-way sweep that is made to stop at a leg boundary. The stimulus arms `auto_rpt_i`, lets the sweep run for several legs while it tracks the extreme set-points and checks that `busy_o` never drops, and then clears `auto_rpt_i` mid-leg. Once the block goes idle, the final set-point must match whichever end the reported direction implies. Carry across the fraction/integer boundary is reached by starting a few LSBs below an integer rollover. Trigger rejection is exercised by strobing and pin-pulsing during a ramp and during the wrong source selection, then confirming that the tick count and the final value are unchanged.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_RAMP,
    S_DWELL,
    S_END
  } sweep_state_e;
endpackage

// File: rtl/sweep_trig.sv
module sweep_trig #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_pin_i,
  input  logic strobe_i,
  input  logic pin_i,
  output logic go_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pin_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];

  assign go_o = sel_pin_i ? (sync_q[SYNC_STAGES-1] & ~prev_q) : strobe_i;

  // R9: pin edge yields a single-cycle pulse
  p_pin_pulse_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_pin_i && go_o) |=> (!go_o || !$stable(sel_pin_i)));
endmodule

// File: rtl/sweep_fsm.sv
module sweep_fsm
  import sweep_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             go_i,
  input  logic             one_way_i,
  input  logic             auto_rpt_i,
  input  logic             start_down_i,
  input  logic             dly_en_i,
  input  logic [CNT_W-1:0] dly_val_i,
  input  logic [CNT_W-1:0] cnt_up_i,
  input  logic [CNT_W-1:0] cnt_dn_i,
  input  logic [CNT_W-1:0] dwell_up_i,
  input  logic [CNT_W-1:0] dwell_dn_i,
  output logic             load_o,
  output logic             step_o,
  output logic             dir_o,
  output logic             busy_o,
  output logic             end_o,
  output logic             wait_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  sweep_state_e     state_q, launch_st;
  logic [CNT_W-1:0] cnt_q, launch_cnt, leg_n, leg_w, cur_w;
  logic             dir_q, loaded_q, need_load, launch_dir;

  always_comb begin
    need_load = !loaded_q || one_way_i;
    if (state_q == S_END)                       launch_dir = one_way_i ? start_down_i : ~dir_q;
    else if (state_q == S_IDLE && need_load)    launch_dir = start_down_i;
    else                                        launch_dir = dir_q;
    leg_n = launch_dir ? cnt_dn_i   : cnt_up_i;
    leg_w = launch_dir ? dwell_dn_i : dwell_up_i;
    cur_w = dir_q      ? dwell_dn_i : dwell_up_i;
    // zero-length phases are skipped so no tick is spent in them
    if (leg_n != '0) begin
      launch_st  = S_RAMP;
      launch_cnt = leg_n;
    end else if (leg_w != '0) begin
      launch_st  = S_DWELL;
      launch_cnt = leg_w;
    end else begin
      launch_st  = S_END;
      launch_cnt = '0;
    end
  end

  assign load_o = (state_q == S_IDLE && go_i && need_load) || (state_q == S_END && one_way_i);
  assign step_o = (state_q == S_RAMP) && tick_i;
  assign dir_o  = dir_q;
  assign busy_o = (state_q != S_IDLE);
  assign end_o  = (state_q == S_END);
  assign wait_o = (state_q == S_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      cnt_q    <= '0;
      dir_q    <= 1'b0;
      loaded_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (go_i) begin
          loaded_q <= 1'b1;
          dir_q    <= launch_dir;
          if (dly_en_i && dly_val_i > ONE) begin
            state_q <= S_WAIT;
            cnt_q   <= dly_val_i - ONE;
          end else begin
            state_q <= launch_st;
            cnt_q   <= launch_cnt;
          end
        end
        S_WAIT: if (tick_i) begin
          if (cnt_q == ONE) begin
            state_q <= launch_st;
            cnt_q   <= launch_cnt;
          end else cnt_q <= cnt_q - ONE;
        end
        S_RAMP: if (tick_i) begin
          if (cnt_q == ONE) begin
            state_q <= (cur_w != '0) ? S_DWELL : S_END;
            cnt_q   <= cur_w;
          end else cnt_q <= cnt_q - ONE;
        end
        S_DWELL: if (tick_i) begin
          if (cnt_q == ONE) state_q <= S_END;
          else              cnt_q   <= cnt_q - ONE;
        end
        S_END: begin
          dir_q <= launch_dir;
          if (auto_rpt_i) begin
            state_q <= launch_st;
            cnt_q   <= launch_cnt;
          end else begin
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R6: two-way leg end flips the direction
  p_dir_flip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_END && !one_way_i) |=> (dir_q != $past(dir_q)));
  // R2: no tick, no progress through the ramp
  p_ramp_waits_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RAMP && !tick_i) |=> (state_q == S_RAMP));
  // R3: counted phases never hold a zero count
  p_count_live_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RAMP || state_q == S_DWELL || state_q == S_WAIT) |-> (cnt_q != '0));
endmodule

// File: rtl/sweep_acc.sv
module sweep_acc #(
  parameter int INT_W  = 20,
  parameter int FRAC_W = 48
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic                    step_i,
  input  logic                    down_i,
  input  logic                    asym_i,
  input  logic [INT_W+FRAC_W-1:0] start_i,
  input  logic [FRAC_W-1:0]       up_mag_i,
  input  logic [FRAC_W-1:0]       dn_mag_i,
  output logic [INT_W+FRAC_W-1:0] sp_o
);
  localparam int SP_W = INT_W + FRAC_W;

  logic [SP_W-1:0]   sp_q, delta;
  logic [FRAC_W-1:0] mag;

  assign mag   = (down_i && asym_i) ? dn_mag_i : up_mag_i;
  assign delta = {{INT_W{1'b0}}, mag};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (load_i) sp_q <= start_i;
    else if (step_i) sp_q <= down_i ? (sp_q - delta) : (sp_q + delta);
  end

  assign sp_o = sp_q;
endmodule

// File: rtl/sweep_seq.sv
module sweep_seq
  import sweep_pkg::*;
#(
  parameter int INT_W  = 20,
  parameter int FRAC_W = 48,
  parameter int CNT_W  = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ref_tick_i,
  input  logic                    one_way_i,
  input  logic                    auto_rpt_i,
  input  logic                    start_down_i,
  input  logic                    asym_i,
  input  logic                    trig_sel_i,
  input  logic                    trig_reg_i,
  input  logic                    trig_pin_i,
  input  logic                    dly_en_i,
  input  logic [CNT_W-1:0]        dly_val_i,
  input  logic [INT_W+FRAC_W-1:0] start_val_i,
  input  logic [FRAC_W-1:0]       step_up_i,
  input  logic [FRAC_W-1:0]       step_dn_i,
  input  logic [CNT_W-1:0]        cnt_up_i,
  input  logic [CNT_W-1:0]        cnt_dn_i,
  input  logic [CNT_W-1:0]        dwell_up_i,
  input  logic [CNT_W-1:0]        dwell_dn_i,
  output logic [INT_W+FRAC_W-1:0] setpoint_o,
  output logic                    busy_o,
  output logic                    dir_down_o
);
  logic go, load, step, end_w, wait_w;

  sweep_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk_i, .rst_ni,
    .sel_pin_i (trig_sel_i),
    .strobe_i  (trig_reg_i),
    .pin_i     (trig_pin_i),
    .go_o      (go)
  );

  sweep_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni,
    .tick_i       (ref_tick_i),
    .go_i         (go),
    .one_way_i, .auto_rpt_i, .start_down_i, .dly_en_i, .dly_val_i,
    .cnt_up_i, .cnt_dn_i, .dwell_up_i, .dwell_dn_i,
    .load_o (load),
    .step_o (step),
    .dir_o  (dir_down_o),
    .busy_o (busy_o),
    .end_o  (end_w),
    .wait_o (wait_w)
  );

  sweep_acc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
    .clk_i, .rst_ni,
    .load_i   (load),
    .step_i   (step),
    .down_i   (dir_down_o),
    .asym_i,
    .start_i  (start_val_i),
    .up_mag_i (step_up_i),
    .dn_mag_i (step_dn_i),
    .sp_o     (setpoint_o)
  );

  // R2: set-point moves only on a tick, a leg end or an accepted trigger
  p_tick_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_tick_i && !end_w && !(go && !busy_o)) |=> $stable(setpoint_o));
  // R10: nothing moves during the launch delay
  p_delay_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_w |=> $stable(setpoint_o));
  // R7: one-way leg end returns to start
  p_jump_back_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_w && one_way_i) |=> (setpoint_o == $past(start_val_i)));
  // R11: a running leg is not cut short by triggers
  p_busy_keeps_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !end_w) |=> busy_o);
endmodule

// File: tb/sweep_seq_bench.sv
module sweep_seq_bench;
  logic        clk = 0, rst_ni = 0, ref_tick = 0;
  logic        one_way = 0, auto_rpt = 0, start_down = 0, asym = 0;
  logic        trig_sel = 0, trig_reg = 0, trig_pin = 0, dly_en = 0;
  logic [47:0] dly_val = 0, step_up = 0, step_dn = 0;
  logic [47:0] cnt_up = 0, cnt_dn = 0, dwell_up = 0, dwell_dn = 0;
  logic [67:0] start_val = 0;
  logic [67:0] setpoint;
  logic        busy, dir_down;

  int errors = 0, checks = 0, cyc = 0, busy_ticks = 0;

  always #2 clk = ~clk;

  sweep_seq u_sweep_seq (
    .clk_i(clk), .rst_ni, .ref_tick_i(ref_tick), .one_way_i(one_way),
    .auto_rpt_i(auto_rpt), .start_down_i(start_down), .asym_i(asym),
    .trig_sel_i(trig_sel), .trig_reg_i(trig_reg), .trig_pin_i(trig_pin),
    .dly_en_i(dly_en), .dly_val_i(dly_val), .start_val_i(start_val),
    .step_up_i(step_up), .step_dn_i(step_dn), .cnt_up_i(cnt_up),
    .cnt_dn_i(cnt_dn), .dwell_up_i(dwell_up), .dwell_dn_i(dwell_dn),
    .setpoint_o(setpoint), .busy_o(busy), .dir_down_o(dir_down)
  );

  // tick every 4 clocks; count ticks the design sees while busy
  always @(negedge clk) begin
    logic nt;
    nt = (cyc % 4 == 0);
    if (busy && nt) busy_ticks <= busy_ticks + 1;
    ref_tick <= nt;
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic wait_idle(output int ticks, output logic [67:0] mn, output logic [67:0] mx, input int t0);
    int g = 0;
    mn = setpoint; mx = setpoint;
    while (busy && g < 20000) begin
      if (setpoint < mn) mn = setpoint;
      if (setpoint > mx) mx = setpoint;
      @(negedge clk); g++;
    end
    ticks = busy_ticks - t0;
  endtask

  task automatic leg_reg(output int ticks, output logic [67:0] mn, output logic [67:0] mx);
    int t0;
    t0 = busy_ticks;
    trig_reg = 1;
    @(negedge clk) trig_reg = 0;
    wait_idle(ticks, mn, mx, t0);
  endtask

  localparam logic [67:0] S2 = {20'd25, 48'hFFFF_FFFF_FFF0};

  task automatic t_reset();
    chk("R1 setpoint", setpoint, 0);
    chk("R1 busy", busy, 0);
    chk("R1 dir", dir_down, 0);
  endtask

  task automatic t_two_way_sym();
    int tk; logic [67:0] mn, mx;
    start_val = S2; step_up = 48'h20; step_dn = 48'h7;
    cnt_up = 3; dwell_up = 2; cnt_dn = 2; dwell_dn = 1;
    leg_reg(tk, mn, mx);
    chk("R3 up ticks", tk, 5);
    chk("R2 carry into integer", setpoint, {20'd26, 48'h50});
    chk("R6 dir flipped", dir_down, 1);
    leg_reg(tk, mn, mx);
    chk("R3 down ticks", tk, 3);
    chk("R4 symmetric down", setpoint, S2 + 68'h20);
    chk("R6 dir back", dir_down, 0);
  endtask

  task automatic t_asym();
    int tk; logic [67:0] mn, mx;
    asym = 1;
    leg_reg(tk, mn, mx);
    chk("R4 asym up", setpoint, S2 + 68'h80);
    leg_reg(tk, mn, mx);
    chk("R4 asym down", setpoint, S2 + 68'h72);
    asym = 0;
  endtask

  task automatic t_busy_ignore();
    int t0, tk; logic [67:0] mn, mx;
    t0 = busy_ticks;
    trig_reg = 1;
    @(negedge clk) trig_reg = 0;
    repeat (6) @(negedge clk);
    trig_reg = 1;
    @(negedge clk) trig_reg = 0;
    wait_idle(tk, mn, mx, t0);
    chk("R11 ticks unchanged", tk, 5);
    chk("R11 final value", setpoint, S2 + 68'hD2);
    repeat (20) @(negedge clk);
    chk("R11 no late start", busy, 0);
  endtask

  task automatic t_zero_count();
    int tk; logic [67:0] mn, mx;
    cnt_dn = 0; dwell_dn = 1;
    leg_reg(tk, mn, mx);
    chk("R12 dwell only ticks", tk, 1);
    chk("R12 no step", setpoint, S2 + 68'hD2);
    chk("R12 dir flipped", dir_down, 0);
  endtask

  localparam logic [67:0] S6 = {20'd100, 48'h0};

  task automatic t_one_way();
    int tk; logic [67:0] mn, mx;
    do_reset();
    one_way = 1; start_down = 1; start_val = S6; step_up = 5;
    cnt_dn = 4; dwell_dn = 2;
    leg_reg(tk, mn, mx);
    chk("R7 ticks", tk, 6);
    chk("R5 ramp went down", mn, S6 - 68'd20);
    chk("R7 back at start", setpoint, S6);
    chk("R5 dir from start_down", dir_down, 1);
  endtask

  task automatic t_trig_sel();
    int t0, tk; logic [67:0] mn, mx;
    trig_pin = 1; repeat (3) @(negedge clk); trig_pin = 0;
    repeat (12) @(negedge clk);
    chk("R9 pin ignored", busy, 0);
    trig_sel = 1;
    repeat (4) @(negedge clk);
    trig_reg = 1; @(negedge clk) trig_reg = 0;
    repeat (12) @(negedge clk);
    chk("R9 strobe ignored", busy, 0);
    t0 = busy_ticks;
    trig_pin = 1; repeat (5) @(negedge clk);
    chk("R9 pin edge starts", busy, 1);
    trig_pin = 0;
    wait_idle(tk, mn, mx, t0);
    chk("R9 pin leg ticks", tk, 6);
    chk("R9 pin leg reached", mn, S6 - 68'd20);
    trig_sel = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_delay();
    int tk; logic [67:0] mn, mx;
    dly_en = 1; dly_val = 3;
    leg_reg(tk, mn, mx);
    chk("R10 delay 3 ticks", tk, 8);
    chk("R10 value", setpoint, S6);
    dly_val = 1;
    leg_reg(tk, mn, mx);
    chk("R10 delay 1 ticks", tk, 6);
    dly_en = 0;
  endtask

  localparam logic [67:0] S9 = {20'd7, 48'h0};

  task automatic t_auto();
    int tk, t0, drops = 0; logic [67:0] mn, mx;
    do_reset();
    one_way = 0; auto_rpt = 1; start_down = 0; start_val = S9; step_up = 48'h100;
    cnt_up = 2; dwell_up = 1; cnt_dn = 2; dwell_dn = 1;
    t0 = busy_ticks;
    trig_reg = 1; @(negedge clk) trig_reg = 0;
    mn = setpoint; mx = setpoint;
    for (int i = 0; i < 44; i++) begin
      if (!busy) drops++;
      if (setpoint < mn) mn = setpoint;
      if (setpoint > mx) mx = setpoint;
      @(negedge clk);
    end
    chk("R8 never idle", drops, 0);
    chk("R8 top", mx, S9 + 68'h200);
    chk("R8 bottom", mn, S9);
    auto_rpt = 0;
    wait_idle(tk, mn, mx, t0);
    chk("R8 stops", busy, 0);
    chk("R8 final end", setpoint, dir_down ? S9 + 68'h200 : S9);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_two_way_sym();
    t_asym();
    t_busy_ignore();
    t_zero_count();
    t_one_way();
    t_trig_sel();
    t_delay();
    t_auto();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule